// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the execution unit of a small 8-bit processor core and carries out the two multi-cycle memory sequences that bracket an interrupt handler. When a request is accepted at an instruction boundary, it saves the program counter, accumulator, index byte and condition codes to a downward-growing byte stack. It then sets the interrupt mask, reads the 16-bit handler address for the most urgent pending source, and prefetches the first three program bytes at that address into a small instruction queue. When a return is requested, it reads the five saved bytes back in the reverse order and hands them to the core. The mask bit is restored from the saved condition codes.

The block owns the stack pointer and the interrupt mask bit. All memory traffic goes through one synchronous byte port: address, write data and strobes are registered, and read data is returned one cycle after the read strobe. Decoding instructions, the arithmetic unit and clearing the peripheral flags are handled elsewhere in the core.

Top module: `irq_frame_top`

## Requirements
- R1: After reset the mask output `imask` is 1, `busy` is 0, `sp` equals the `SP_RESET` parameter, and neither memory strobe is active.
- R2: An interrupt is accepted only on a clock edge where `insn_done` is 1, at least one `irq_req` bit is set, `imask` is 0 and the block is idle. A request under any other condition starts no memory cycle and leaves `sp` unchanged.
- R3: On entry exactly five bytes are written, one per cycle starting on the cycle after acceptance, in the order: PC low, PC high, X, A, CCR. They go to addresses SP0, SP0-1, SP0-2, SP0-3 and SP0-4, where SP0 is the stack pointer before entry. The high index byte is never written.
- R4: The stack pointer always names the next free byte. Every write goes to `sp`+1 as seen after that write, and after entry `sp` equals SP0-5.
- R5: The PC stored is the `cpu_pc` value present at acceptance, i.e. the next instruction's address. The CCR stored is `cpu_ccr` with bit `IBIT` (default 3) replaced by the pre-entry mask value, which is 0.
- R6: The mask output becomes 1 at acceptance and stays 1 for the whole entry sequence.
- R7: With several `irq_req` bits set, the lowest-numbered bit wins. The handler address for source i is read high byte first from `VEC_BASE`+2i and low byte from `VEC_BASE`+2i+1, and it appears on `handler_pc`.
- R8: After the vector is read, the bytes at handler, handler+1 and handler+2 are read and presented on `iq_bytes` bits [7:0], [15:8] and [23:16].
- R9: `busy` is high for exactly 12 cycles on entry and 6 cycles on return. `entry_done` or `ret_done` is a one-cycle pulse in the first cycle after `busy` falls. Return or interrupt requests raised while busy are ignored.
- R10: A return reads SP0+1 to SP0+5 as CCR, A, X, PC high and PC low. These values are presented on `ret_ccr`, `ret_a`, `ret_x` and `ret_pc`, `sp` ends at SP0+5, and `imask` takes bit `IBIT` of the read CCR. No byte is written.
- R11: When `rti_req` and an acceptable interrupt arrive on the same edge, the return sequence is taken and the interrupt is not.
- R12: A `mask_clr` pulse while idle clears `imask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_done | input | 1 | High on the cycle the current instruction completes |
| irq_req | input | NSRC | Pending requests, bit 0 most urgent |
| rti_req | input | 1 | Start the return sequence |
| mask_clr | input | 1 | Software clear of the interrupt mask |
| cpu_pc | input | 16 | Address of the next instruction |
| cpu_a | input | 8 | Accumulator |
| cpu_x | input | 8 | Low index byte |
| cpu_ccr | input | 8 | Condition codes |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data one cycle later |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| sp | output | 16 | Stack pointer, next free byte |
| imask | output | 1 | Interrupt mask bit |
| busy | output | 1 | A sequence is in progress |
| handler_pc | output | 16 | Handler address read from the vector |
| iq_bytes | output | 24 | Three prefetched program bytes |
| entry_done | output | 1 | Entry finished pulse |
| ret_done | output | 1 | Return finished pulse |
| ret_pc | output | 16 | Restored program counter |
| ret_a | output | 8 | Restored accumulator |
| ret_x | output | 8 | Restored index byte |
| ret_ccr | output | 8 | Restored condition codes |

## Verification
A wrong step count or a misordered step shows up directly at the ports. On the next edge, the stack bytes land at shifted addresses, `sp` drifts from SP0-5, or a read is issued at an address other than the vector slot. A wrong priority pick or vector read appears 12 cycles after acceptance as a wrong `handler_pc` and queue contents. A broken mask or pop path becomes visible after the following return: the restored values or `imask` differ, or a later request is accepted or refused wrongly.

// File: rtl/irq_frame_pkg.sv
package irq_frame_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int STEP_W = 4;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_ENTRY  = 2'd1,
    MODE_RETURN = 2'd2
  } seq_mode_e;
endpackage

// File: rtl/irq_frame_prio.sv
module irq_frame_prio #(
  parameter int NSRC = 8,
  parameter int IW   = 3
) (
  input  logic [NSRC-1:0] req,
  output logic            any,
  output logic [IW-1:0]   idx
);
  // lowest set bit wins: scan from the top so the last hit is the lowest
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_frame_ctrl.sv
module irq_frame_ctrl
  import irq_frame_pkg::*;
#(
  parameter int                NSRC     = 8,
  parameter int                IW       = 3,
  parameter int                IBIT     = 3,
  parameter logic [ADDR_W-1:0] SP_RESET = 16'h00FF,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFE0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_done,
  input  logic              rti_req,
  input  logic              mask_clr,
  input  logic              req_any,
  input  logic [IW-1:0]     req_idx,
  input  logic [ADDR_W-1:0] cpu_pc,
  input  logic [BYTE_W-1:0] cpu_a,
  input  logic [BYTE_W-1:0] cpu_x,
  input  logic [BYTE_W-1:0] cpu_ccr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] sp,
  output logic              imask,
  output logic              busy,
  output logic [ADDR_W-1:0] handler_pc,
  output logic [3*BYTE_W-1:0] iq_bytes,
  output logic              entry_done,
  output logic              ret_done,
  output logic [ADDR_W-1:0] ret_pc,
  output logic [BYTE_W-1:0] ret_a,
  output logic [BYTE_W-1:0] ret_x,
  output logic [BYTE_W-1:0] ret_ccr
);
  seq_mode_e         mode;
  logic [STEP_W-1:0] step;
  logic [ADDR_W-1:0] snap_pc;
  logic [BYTE_W-1:0] snap_a, snap_x, snap_ccr, vec_hi, ccr_stk;
  logic [IW-1:0]     vidx;
  logic [ADDR_W-1:0] vec_addr, hnd_now;

  always_comb begin
    ccr_stk       = cpu_ccr;
    ccr_stk[IBIT] = imask;
  end

  assign vec_addr = VEC_BASE + (ADDR_W'(vidx) << 1);
  assign hnd_now  = {vec_hi, mem_rdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= MODE_IDLE;
      step       <= '0;
      sp         <= SP_RESET;
      imask      <= 1'b1;
      busy       <= 1'b0;
      mem_addr   <= '0;
      mem_we     <= 1'b0;
      mem_re     <= 1'b0;
      mem_wdata  <= '0;
      snap_pc    <= '0;
      snap_a     <= '0;
      snap_x     <= '0;
      snap_ccr   <= '0;
      vidx       <= '0;
      vec_hi     <= '0;
      handler_pc <= '0;
      iq_bytes   <= '0;
      entry_done <= 1'b0;
      ret_done   <= 1'b0;
      ret_pc     <= '0;
      ret_a      <= '0;
      ret_x      <= '0;
      ret_ccr    <= '0;
    end else begin
      mem_we     <= 1'b0;
      mem_re     <= 1'b0;
      entry_done <= 1'b0;
      ret_done   <= 1'b0;
      step       <= step + 1'b1;
      unique case (mode)
        MODE_IDLE: begin
          step <= '0;
          if (mask_clr) imask <= 1'b0;
          if (rti_req) begin
            mode     <= MODE_RETURN;
            busy     <= 1'b1;
            step     <= 4'd1;
            mem_re   <= 1'b1;
            mem_addr <= sp + 1'b1;
            sp       <= sp + 1'b1;
          end else if (insn_done && req_any && !imask) begin
            mode      <= MODE_ENTRY;
            busy      <= 1'b1;
            step      <= 4'd1;
            imask     <= 1'b1;
            snap_pc   <= cpu_pc;
            snap_a    <= cpu_a;
            snap_x    <= cpu_x;
            snap_ccr  <= ccr_stk;
            vidx      <= req_idx;
            mem_we    <= 1'b1;
            mem_addr  <= sp;
            mem_wdata <= cpu_pc[BYTE_W-1:0];
            sp        <= sp - 1'b1;
          end
        end
        MODE_ENTRY: begin
          case (step)
            4'd1, 4'd2, 4'd3, 4'd4: begin
              mem_we   <= 1'b1;
              mem_addr <= sp;
              sp       <= sp - 1'b1;
              case (step)
                4'd1:    mem_wdata <= snap_pc[ADDR_W-1:BYTE_W];
                4'd2:    mem_wdata <= snap_x;
                4'd3:    mem_wdata <= snap_a;
                default: mem_wdata <= snap_ccr;
              endcase
            end
            4'd5: begin
              mem_re   <= 1'b1;
              mem_addr <= vec_addr;
            end
            4'd6: begin
              mem_re   <= 1'b1;
              mem_addr <= vec_addr + 1'b1;
            end
            4'd7: vec_hi <= mem_rdata;
            4'd8: begin
              handler_pc <= hnd_now;
              mem_re     <= 1'b1;
              mem_addr   <= hnd_now;
            end
            4'd9: begin
              mem_re   <= 1'b1;
              mem_addr <= handler_pc + 1'b1;
            end
            4'd10: begin
              mem_re        <= 1'b1;
              mem_addr      <= handler_pc + 2'd2;
              iq_bytes[7:0] <= mem_rdata;
            end
            4'd11: iq_bytes[15:8] <= mem_rdata;
            default: begin
              iq_bytes[23:16] <= mem_rdata;
              busy            <= 1'b0;
              entry_done      <= 1'b1;
              mode            <= MODE_IDLE;
              step            <= '0;
            end
          endcase
        end
        MODE_RETURN: begin
          if (step <= 4'd4) begin
            mem_re   <= 1'b1;
            mem_addr <= sp + 1'b1;
            sp       <= sp + 1'b1;
          end
          case (step)
            4'd2: ret_ccr <= mem_rdata;
            4'd3: ret_a   <= mem_rdata;
            4'd4: ret_x   <= mem_rdata;
            4'd5: ret_pc[ADDR_W-1:BYTE_W] <= mem_rdata;
            4'd6: begin
              ret_pc[BYTE_W-1:0] <= mem_rdata;
              imask              <= ret_ccr[IBIT];
              busy               <= 1'b0;
              ret_done           <= 1'b1;
              mode               <= MODE_IDLE;
              step               <= '0;
            end
            default: ;
          endcase
        end
        default: mode <= MODE_IDLE;
      endcase
    end
  end

  AST_SP_NEXT_FREE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == sp + 1'b1)); // R4
  AST_POP_ADDR_UP: assert property (@(posedge clk) disable iff (rst)
    (mem_re && mode == MODE_RETURN) |-> (mem_addr == sp)); // R10
  AST_MASK_HELD_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_ENTRY) |-> imask); // R6
  AST_MASKED_NO_ENTRY: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && $past(imask)) |-> (mode == MODE_RETURN)); // R2
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    (entry_done || ret_done) |-> (!busy && $past(busy))); // R9
  AST_RET_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RETURN) |-> !mem_we); // R10
endmodule

// File: rtl/irq_frame_top.sv
module irq_frame_top
  import irq_frame_pkg::*;
#(
  parameter int                NSRC     = 8,
  parameter int                IBIT     = 3,
  parameter logic [ADDR_W-1:0] SP_RESET = 16'h00FF,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFE0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                insn_done,
  input  logic [NSRC-1:0]     irq_req,
  input  logic                rti_req,
  input  logic                mask_clr,
  input  logic [15:0]         cpu_pc,
  input  logic [7:0]          cpu_a,
  input  logic [7:0]          cpu_x,
  input  logic [7:0]          cpu_ccr,
  output logic [15:0]         mem_addr,
  output logic                mem_we,
  output logic                mem_re,
  output logic [7:0]          mem_wdata,
  input  logic [7:0]          mem_rdata,
  output logic [15:0]         sp,
  output logic                imask,
  output logic                busy,
  output logic [15:0]         handler_pc,
  output logic [23:0]         iq_bytes,
  output logic                entry_done,
  output logic                ret_done,
  output logic [15:0]         ret_pc,
  output logic [7:0]          ret_a,
  output logic [7:0]          ret_x,
  output logic [7:0]          ret_ccr
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic          req_any;
  logic [IW-1:0] req_idx;

  irq_frame_prio #(.NSRC(NSRC), .IW(IW)) u_prio (
    .req (irq_req),
    .any (req_any),
    .idx (req_idx)
  );

  irq_frame_ctrl #(
    .NSRC(NSRC), .IW(IW), .IBIT(IBIT), .SP_RESET(SP_RESET), .VEC_BASE(VEC_BASE)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .insn_done  (insn_done),
    .rti_req    (rti_req),
    .mask_clr   (mask_clr),
    .req_any    (req_any),
    .req_idx    (req_idx),
    .cpu_pc     (cpu_pc),
    .cpu_a      (cpu_a),
    .cpu_x      (cpu_x),
    .cpu_ccr    (cpu_ccr),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .sp         (sp),
    .imask      (imask),
    .busy       (busy),
    .handler_pc (handler_pc),
    .iq_bytes   (iq_bytes),
    .entry_done (entry_done),
    .ret_done   (ret_done),
    .ret_pc     (ret_pc),
    .ret_a      (ret_a),
    .ret_x      (ret_x),
    .ret_ccr    (ret_ccr)
  );
endmodule

// File: tb/irq_frame_top_tb.sv
module irq_frame_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SP0  = 16'h01FF;
  localparam logic [15:0] VECB = 16'h03E0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_done = 1'b0;
  logic [7:0]  irq_req = '0;
  logic        rti_req = 1'b0;
  logic        mask_clr = 1'b0;
  logic [15:0] cpu_pc = '0;
  logic [7:0]  cpu_a = '0, cpu_x = '0, cpu_ccr = '0;
  logic [15:0] mem_addr, sp, handler_pc, ret_pc;
  logic        mem_we, mem_re, imask, busy, entry_done, ret_done;
  logic [7:0]  mem_wdata, ret_a, ret_x, ret_ccr;
  logic [7:0]  mem_rdata = '0;
  logic [23:0] iq_bytes;

  logic [7:0]  bmem [0:1023];
  logic        ld_en = 1'b0;
  logic [9:0]  ld_addr = '0;
  logic [7:0]  ld_data = '0;
  int          wr_total = 0;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 1'b0;
  logic [15:0] exp_sp;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (ld_en) bmem[ld_addr] <= ld_data;
    else if (mem_we) bmem[mem_addr[9:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= bmem[mem_addr[9:0]];
    if (mem_we) wr_total <= wr_total + 1;
  end

  irq_frame_top #(.NSRC(8), .IBIT(3), .SP_RESET(SP0), .VEC_BASE(VECB)) u_dut (
    .clk(clk), .rst(rst), .insn_done(insn_done), .irq_req(irq_req),
    .rti_req(rti_req), .mask_clr(mask_clr), .cpu_pc(cpu_pc), .cpu_a(cpu_a),
    .cpu_x(cpu_x), .cpu_ccr(cpu_ccr), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sp(sp),
    .imask(imask), .busy(busy), .handler_pc(handler_pc), .iq_bytes(iq_bytes),
    .entry_done(entry_done), .ret_done(ret_done), .ret_pc(ret_pc),
    .ret_a(ret_a), .ret_x(ret_x), .ret_ccr(ret_ccr)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic poke(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic load_image();
    @(negedge clk);
    ld_en = 1'b1;
    for (int a = 0; a < 1024; a++) begin
      ld_addr = 10'(a);
      if (a >= 16'h03E0) ld_data = (a[0] == 1'b0) ? 8'h03 : 8'(((a - 16'h03E0) >> 1) * 16);
      else ld_data = pat(16'(a));
      @(negedge clk);
    end
    ld_en = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(imask == 1'b1, "R1", "imask", imask, 1);
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(sp == SP0, "R1", "sp", sp, SP0);
    chk(!mem_we && !mem_re, "R1", "strobes", {mem_we, mem_re}, 0);
  endtask

  task automatic t_masked();
    int w0;
    w0 = wr_total;
    @(negedge clk);
    irq_req = 8'h04; insn_done = 1'b1;
    repeat (3) @(negedge clk);
    insn_done = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R2", "masked busy", busy, 0);
    chk(sp == SP0, "R2", "masked sp", sp, SP0);
    chk(wr_total == w0, "R2", "masked writes", wr_total - w0, 0);
    mask_clr = 1'b1;
    @(negedge clk);
    mask_clr = 1'b0;
    chk(imask == 1'b0, "R12", "mask cleared", imask, 0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && sp == SP0, "R2", "no insn_done no entry", busy, 0);
    irq_req = '0;
  endtask

  task automatic t_entry(input logic [7:0] req, input logic [15:0] pc,
                         input logic [7:0] a, input logic [7:0] x,
                         input logic [7:0] ccr, input int idx);
    int w0, n;
    logic [15:0] s0, hnd;
    s0 = exp_sp; w0 = wr_total;
    hnd = 16'h0300 + 16'(idx * 16);
    @(negedge clk);
    irq_req = req; cpu_pc = pc; cpu_a = a; cpu_x = x; cpu_ccr = ccr; insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0; irq_req = '0;
    n = 0;
    while (busy && n < 40) begin
      n++;
      rti_req = (n == 3);
      irq_req = (n == 5) ? 8'hFF : 8'h00;
      insn_done = (n == 5);
      @(negedge clk);
    end
    rti_req = 1'b0; irq_req = '0; insn_done = 1'b0;
    chk(n == 12, "R9", "entry busy cycles", n, 12);
    chk(entry_done == 1'b1, "R9", "entry_done", entry_done, 1);
    chk(wr_total - w0 == 5, "R3", "write count (H not pushed)", wr_total - w0, 5);
    chk(bmem[s0[9:0]] == pc[7:0], "R3", "PCL slot", bmem[s0[9:0]], pc[7:0]);
    chk(bmem[10'(s0 - 1)] == pc[15:8], "R5", "PCH slot", bmem[10'(s0 - 1)], pc[15:8]);
    chk(bmem[10'(s0 - 2)] == x, "R3", "X slot", bmem[10'(s0 - 2)], x);
    chk(bmem[10'(s0 - 3)] == a, "R3", "A slot", bmem[10'(s0 - 3)], a);
    chk(bmem[10'(s0 - 4)] == (ccr & 8'hF7), "R5", "CCR slot", bmem[10'(s0 - 4)], ccr & 8'hF7);
    exp_sp = s0 - 16'd5;
    chk(sp == exp_sp, "R4", "sp after entry", sp, exp_sp);
    chk(imask == 1'b1, "R6", "mask after entry", imask, 1);
    chk(handler_pc == hnd, "R7", "handler", handler_pc, hnd);
    chk(iq_bytes == {pat(hnd + 2), pat(hnd + 1), pat(hnd)}, "R8", "queue",
        iq_bytes, {pat(hnd + 2), pat(hnd + 1), pat(hnd)});
  endtask

  task automatic t_return(input bit with_irq, input logic [15:0] epc,
                          input logic [7:0] ea, input logic [7:0] ex,
                          input logic [7:0] eccr);
    int w0, n;
    w0 = wr_total;
    @(negedge clk);
    rti_req = 1'b1;
    if (with_irq) begin irq_req = 8'h01; insn_done = 1'b1; end
    @(negedge clk);
    rti_req = 1'b0; irq_req = '0; insn_done = 1'b0;
    n = 0;
    while (busy && n < 40) begin n++; @(negedge clk); end
    chk(n == 6, with_irq ? "R11" : "R9", "return busy cycles", n, 6);
    chk(ret_done == 1'b1, "R9", "ret_done", ret_done, 1);
    chk(wr_total == w0, with_irq ? "R11" : "R10", "return writes", wr_total - w0, 0);
    chk(ret_ccr == eccr, "R10", "ret_ccr", ret_ccr, eccr);
    chk(ret_a == ea, "R10", "ret_a", ret_a, ea);
    chk(ret_x == ex, "R10", "ret_x", ret_x, ex);
    chk(ret_pc == epc, "R10", "ret_pc", ret_pc, epc);
    exp_sp = exp_sp + 16'd5;
    chk(sp == exp_sp, "R10", "sp after return", sp, exp_sp);
    chk(imask == eccr[3], "R10", "mask restored", imask, eccr[3]);
  endtask

  task automatic t_clear();
    @(negedge clk);
    mask_clr = 1'b1;
    @(negedge clk);
    mask_clr = 1'b0;
    chk(imask == 1'b0, "R12", "mask cleared", imask, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    exp_sp = SP0;
    t_reset();
    load_image();
    t_masked();
    // source 2 wins over 5 and 7 (R7); CCR bit 3 stored as 0 (R5)
    t_entry(8'b1010_0100, 16'hA5C3, 8'h11, 8'h22, 8'hFF, 2);
    t_return(1'b0, 16'hA5C3, 8'h11, 8'h22, 8'hF7);
    // R11: return and request together, pops pattern bytes above the stack
    t_return(1'b1, {pat(16'h0203), pat(16'h0204)}, pat(16'h0201), pat(16'h0202), pat(16'h0200));
    t_clear();
    t_entry(8'h81, 16'h1234, 8'h9A, 8'hBC, 8'h00, 0);
    poke(10'(exp_sp + 1), 8'h08);
    t_return(1'b0, 16'h1234, 8'h9A, 8'hBC, 8'h08);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule